// File: doc/BRIEF.md
# Rate-1/2 Punctured Parallel Turbo Encoder

This block encodes fixed-length frames of information bits. It uses two identical recursive systematic convolutional encoders. Bits arrive serially, one per cycle in which `bit_valid` is high, and the first bit of a frame is flagged with `frame_start`. The whole frame is held in a register, because the second encoder reads the frame in a permuted order.

Once the last bit has been taken, the block streams one two-bit symbol per cycle. Each symbol carries the systematic bit of the first encoder and one parity bit. That parity bit comes alternately from the first encoder and from the second encoder. Four unpunctured tail symbols follow the data symbols and return both encoders to the zero state.

While the symbol stream is running, the block accepts no input. A frame with N = 16 bits gives 20 output symbols.

Top module: `turbo_enc_punct`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sym` is 2'b00. `out_sym` stays 2'b00 in every cycle in which `out_valid` is 0.
- R2: A frame starts with a cycle that has `bit_valid` and `frame_start` both high; that cycle's `bit_in` is frame bit 0. The next cycles that have `bit_valid` high supply bits 1 to N-1 in order. Cycles with `bit_valid` low are skipped. A valid bit without `frame_start` is ignored when no frame is being collected.
- R3: `out_valid` rises in the cycle after the clock edge that takes bit N-1. It stays high for exactly N+4 consecutive cycles.
- R4: In data symbol i (i = 0..N-1), `out_sym[1]` is frame bit i.
- R5: Both component encoders hold two state bits s1 (newest) and s2. Each step computes a = u ^ s1 ^ s2 and parity = a ^ s2, then moves the state to (a, s1).
- R6: At step i, the second encoder takes frame bit (5*i) mod 16.
- R7: In data symbol i, `out_sym[0]` is the first encoder's parity when i is odd and the second encoder's parity when i is even.
- R8: Tail symbols 0 and 1 are two first-encoder steps, and tail symbols 2 and 3 are two second-encoder steps. Each tail step uses input u = s1 ^ s2 and emits {u, parity}. Both encoders are in state zero when the stream ends.
- R9: Each frame is encoded from state zero, so the same frame always gives the same symbols, whatever frame came before it.
- R10: All inputs are ignored while `out_valid` is high. A `frame_start` with `bit_valid` during collection restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Marks bit 0 of a frame (qualified by bit_valid) |
| bit_valid | input | 1 | Input bit present this cycle |
| bit_in | input | 1 | Information bit |
| out_valid | output | 1 | Symbol present this cycle |
| out_sym | output | 2 | {systematic or tail input, parity} |

## Verification
A new frame request and the encoding stream can fall in the same cycle. The bench provokes this by driving `frame_start` and `bit_valid` in every cycle of a running stream, including its last tail cycle. It then sends fifteen further bits that carry no frame start. The symbols of the running stream must stay correct, and `out_valid` must stay low afterwards. A restart in the middle of collection is also tested: a second `frame_start` is driven before the first frame is complete, and the output must match only the second frame.

// File: rtl/turbo_enc_punct.sv
module turbo_enc_punct #(
  parameter int N = 16,
  parameter int K = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic       out_valid,
  output logic [1:0] out_sym
);
  localparam int CW = $clog2(N);
  localparam int PW = CW + $clog2(K + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] TLAST = CW'(3);

  typedef enum logic [1:0] {IDLE, FILL, ENC, TAIL} ph_t;
  ph_t phase;

  logic [N-1:0]  fbuf;
  logic [CW-1:0] cnt;
  logic [1:0]    us, ls;

  wire first = bit_valid && frame_start && (phase == IDLE || phase == FILL);

  wire [PW-1:0] prod = PW'(K) * PW'(cnt);
  wire [CW-1:0] pidx = CW'(prod % N);
  wire tail_up = (cnt < CW'(2));

  wire uin = (phase == TAIL) ? (us[1] ^ us[0]) : fbuf[cnt];
  wire lin = (phase == TAIL) ? (ls[1] ^ ls[0]) : fbuf[pidx];
  wire ufb = uin ^ us[1] ^ us[0];
  wire lfb = lin ^ ls[1] ^ ls[0];
  wire upar = ufb ^ us[0];
  wire lpar = lfb ^ ls[0];

  wire ustep = (phase == ENC) || (phase == TAIL && tail_up);
  wire lstep = (phase == ENC) || (phase == TAIL && !tail_up);

  assign out_valid = (phase == ENC) || (phase == TAIL);
  always_comb begin
    out_sym = 2'b00;
    if (phase == ENC)
      out_sym = {fbuf[cnt], cnt[0] ? upar : lpar};
    else if (phase == TAIL)
      out_sym = tail_up ? {uin, upar} : {lin, lpar};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      fbuf  <= '0;
      us    <= '0;
      ls    <= '0;
    end else begin
      if (ustep) us <= {ufb, us[1]};
      if (lstep) ls <= {lfb, ls[1]};
      if (first) begin
        fbuf[0] <= bit_in;
        cnt     <= CW'(1);
        us      <= '0;
        ls      <= '0;
        phase   <= FILL;
      end else if (phase == FILL && bit_valid) begin
        fbuf[cnt] <= bit_in;
        if (cnt == LAST) begin
          cnt   <= '0;
          phase <= ENC;
        end else cnt <= cnt + 1'b1;
      end else if (phase == ENC) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          phase <= TAIL;
        end else cnt <= cnt + 1'b1;
      end else if (phase == TAIL) begin
        if (cnt == TLAST) begin
          cnt   <= '0;
          phase <= IDLE;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_sym == 2'b00); // R1
  AST_START_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(bit_valid)); // R3
  AST_STREAM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ($past(phase) == TAIL && $past(cnt) == TLAST)); // R3
  AST_TERMINATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (us == 2'b00 && ls == 2'b00)); // R8
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == FILL) |-> (us == 2'b00 && ls == 2'b00)); // R9
endmodule

// File: tb/tb_turbo_enc_punct.sv
module tb_turbo_enc_punct;
  localparam int CLK_P = 10;
  localparam int NF = 6;
  localparam logic [15:0] FRAMES [NF] =
    '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'hA5C3, 16'h0001};

  logic clk = 0, rst_n = 0, frame_start = 0, bit_valid = 0, bit_in = 0;
  logic out_valid;
  logic [1:0] out_sym;
  int checks = 0, errors = 0;

  turbo_enc_punct dut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .bit_valid(bit_valid), .bit_in(bit_in), .out_valid(out_valid), .out_sym(out_sym));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [15:0] f, input int k);
    logic [1:0] u = 2'b00, l = 2'b00, s = 2'b00;
    for (int i = 0; i <= k; i++) begin
      logic ub, lb, ua, la, up, lp;
      if (i < 16) begin
        ub = f[i]; lb = f[(5*i) % 16];
      end else begin
        ub = u[1] ^ u[0]; lb = l[1] ^ l[0];
      end
      ua = ub ^ u[1] ^ u[0]; up = ua ^ u[0];
      la = lb ^ l[1] ^ l[0]; lp = la ^ l[0];
      if (i < 16) s = {ub, (i % 2 == 1) ? up : lp};
      else if (i < 18) s = {ub, up};
      else s = {lb, lp};
      if (i < 18) u = {ua, u[1]};
      if (i < 16 || i >= 18) l = {la, l[1]};
    end
    return s;
  endfunction

  task automatic send(input logic [15:0] f, input int gap);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      frame_start = (i == 0); bit_valid = 1; bit_in = f[i];
      if (i < 15) for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        frame_start = 0; bit_valid = 0;
      end
    end
    @(negedge clk);
    frame_start = 0; bit_valid = 0; bit_in = 0;
  endtask

  task automatic expect_stream(input logic [15:0] f, input bit inject);
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      chk("R3 valid", {1'b0, out_valid}, 2'b01);
      chk(k < 16 ? "R4 R5 R6 R7 R9 data" : "R8 tail", out_sym, model(f, k));
      if (inject) begin
        frame_start = 1; bit_valid = 1; bit_in = 1;
      end
    end
    @(negedge clk);
    frame_start = 0; bit_valid = 0; bit_in = 0;
    chk("R3 end", {1'b0, out_valid}, 2'b00);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    @(negedge clk);
    chk("R1 valid", {1'b0, out_valid}, 2'b00);
    chk("R1 sym", out_sym, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after", {out_valid, out_sym}, 3'b000);

    for (int n = 0; n < NF; n++) begin
      send(FRAMES[n], 0);
      expect_stream(FRAMES[n], 0);
    end

    // R2: gaps between bits
    send(16'h3C96, 2);
    expect_stream(16'h3C96, 0);

    // R2: stray valid bits while idle are ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bit_valid = 1; bit_in = 1;
      chk("R2 stray", {1'b0, out_valid}, 2'b00);
    end
    @(negedge clk); bit_valid = 0;
    send(16'h1248, 0);
    expect_stream(16'h1248, 0);

    // R10: restart during collection
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      frame_start = (i == 0); bit_valid = 1; bit_in = 1;
    end
    send(16'h0F0F, 0);
    expect_stream(16'h0F0F, 0);

    // R10: inputs ignored while streaming, including the last tail cycle
    send(16'h6D21, 0);
    expect_stream(16'h6D21, 1);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      bit_valid = 1; bit_in = i[0];
    end
    @(negedge clk); bit_valid = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 ignored", {out_valid, out_sym}, 3'b000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule